// File: doc/BRIEF.md
# Instruction operand fetch sequencer

This block pulls one complete instruction of an 8-bit processor out of a byte-wide synchronous memory with a 16-bit address space. A request carries the address of the opcode. The block reads the opcode byte first. While that byte is on the read-data bus, an external decoder maps it to an addressing-mode code on `dec_mode`. From that code the block decides whether zero, one or two operand bytes follow. It then reads them from the next consecutive addresses, one per cycle, with no idle cycle between reads.

When the last byte is in, a one-cycle `done` pulse marks the results as valid. The results are the opcode, two operand bytes (an operand that was not fetched reads as zero) and the instruction length in bytes. The block does not execute anything, hold the opcode-to-mode table or form effective addresses.

Requests enter through a valid/ready pair. `req_ready` is high only while the block is idle, which includes the cycle that carries `done`. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. While the block is busy, `req_valid` and `req_addr` are ignored, and the requester must hold its request until `req_ready` returns. The result side has no back-pressure: results stay on the outputs until the next request is taken.

Top module: `instr_fetch_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `req_ready` is 1, `done` and `mem_rd_en` are 0, and `out_opcode`, `out_op1`, `out_op2` and `out_len` are all zero.
- R2: `req_ready` is 1 only when the block is idle. A request is taken only on an edge with `req_valid` and `req_ready` both high. `req_valid` pulses while busy cause no extra bus read and do not change the results.
- R3: In the cycle after a request is taken, `mem_rd_en` is 1 with `mem_addr` equal to the request address. Each further read addresses the previous read address plus one, modulo 65536. Read data is expected on `mem_rdata` one cycle after `mem_rd_en`.
- R4: Mode codes 2 to 9 fetch exactly one operand byte: immediate, zero page, zero page + X, zero page + Y, zero-page indirect, X-indexed zero-page indirect, zero-page indirect + Y, and relative, in that code order.
- R5: Mode codes 10 to 15 fetch exactly two operand bytes: absolute, absolute + X, absolute + Y, absolute indirect, X-indexed absolute indirect, and zero-page-relative (bit test and branch), in that code order.
- R6: Mode code 0 (implied) and mode code 1 (accumulator) fetch no operand bytes.
- R7: `dec_mode` is sampled only in the cycle in which the opcode byte is on `mem_rdata`. Its value in any other cycle has no effect.
- R8: `out_len` is 1 plus the number of operand bytes fetched. `out_op1` carries the byte from start+1 and `out_op2` the byte from start+2. Any operand byte that is not fetched reads as zero.
- R9: For an instruction with n operand bytes, `done` is high for exactly one cycle, 3+n cycles after the edge that took the request, and the fetch makes exactly 1+n bus reads.
- R10: The result outputs keep their values from the `done` cycle until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A fetch request is offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_addr | input | 16 | Address of the opcode byte |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |
| dec_mode | input | 4 | Addressing-mode code for the opcode now on `mem_rdata` |
| done | output | 1 | One-cycle pulse: results valid |
| out_opcode | output | 8 | Fetched opcode |
| out_op1 | output | 8 | First operand byte, or zero |
| out_op2 | output | 8 | Second operand byte, or zero |
| out_len | output | 2 | Instruction length in bytes, 1 to 3 |

## Verification
The assertions assume that the memory returns data exactly one cycle after each strobe and that the requester never needs a busy block to see its request. They put no demand on `dec_mode` outside the opcode cycle. The stimulus keeps within these limits with a one-cycle-latency memory model. Each request is raised only when `req_ready` is high. Extra `req_valid` pulses are placed only inside busy windows. The decoder is derived from whatever byte is on the read bus, so operand bytes in flight present arbitrary mode codes that must be ignored. The sweep covers all sixteen mode codes against start addresses that include the top of the address space, so that operand addresses wrap.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // Addressing-mode codes presented by the external decoder.
  typedef enum logic [3:0] {
    AM_IMPLIED   = 4'd0,
    AM_ACCUM     = 4'd1,
    AM_IMM       = 4'd2,
    AM_ZPG       = 4'd3,
    AM_ZPG_X     = 4'd4,
    AM_ZPG_Y     = 4'd5,
    AM_ZPG_IND   = 4'd6,
    AM_ZPG_XIND  = 4'd7,
    AM_ZPG_INDY  = 4'd8,
    AM_REL       = 4'd9,
    AM_ABS       = 4'd10,
    AM_ABS_X     = 4'd11,
    AM_ABS_Y     = 4'd12,
    AM_ABS_IND   = 4'd13,
    AM_ABS_XIND  = 4'd14,
    AM_ZPG_REL   = 4'd15
  } addr_mode_e;

  // Controller states.
  typedef enum logic [1:0] {
    FS_IDLE     = 2'd0,
    FS_ISSUE    = 2'd1,
    FS_TAKE_OPC = 2'd2,
    FS_TAKE_OPD = 2'd3
  } fetch_state_e;

endpackage

// File: rtl/fetch_mode_class.sv
module fetch_mode_class
  import fetch_pkg::*;
#(
  parameter int MODE_W  = 4,
  parameter int MAX_OPS = 2,
  localparam int CNT_W  = $clog2(MAX_OPS + 1)
) (
  input  logic [MODE_W-1:0] mode_raw,
  output logic [CNT_W-1:0]  opd_count
);

  addr_mode_e mode;

  always_comb begin
    mode = addr_mode_e'(mode_raw);
    unique case (mode)
      AM_IMM, AM_ZPG, AM_ZPG_X, AM_ZPG_Y,
      AM_ZPG_IND, AM_ZPG_XIND, AM_ZPG_INDY, AM_REL:
        opd_count = CNT_W'(1);
      AM_ABS, AM_ABS_X, AM_ABS_Y,
      AM_ABS_IND, AM_ABS_XIND, AM_ZPG_REL:
        opd_count = CNT_W'(2);
      default:
        opd_count = '0;
    endcase
  end

endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_ld,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_ld) base_q <= base_in;
  end

  // Wraps naturally at the top of the address space.
  assign addr = base_q + {{(ADDR_W-OFF_W){1'b0}}, offset};

endmodule

// File: rtl/fetch_byte_bank.sv
module fetch_byte_bank #(
  parameter int DATA_W  = 8,
  parameter int MAX_OPS = 2,
  localparam int IDX_W  = (MAX_OPS > 1) ? $clog2(MAX_OPS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      cap_opc,
  input  logic                      cap_opd,
  input  logic [IDX_W-1:0]          cap_idx,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         opcode,
  output logic [MAX_OPS*DATA_W-1:0] operands
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       opcode <= '0;
    else if (clear)   opcode <= '0;
    else if (cap_opc) opcode <= wdata;
  end

  for (genvar s = 0; s < MAX_OPS; s++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (clear)
        slot_q <= '0;
      else if (cap_opd && (cap_idx == IDX_W'(s)))
        slot_q <= wdata;
    end
    assign operands[s*DATA_W +: DATA_W] = slot_q;
  end

endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int MAX_OPS = 2,
  localparam int CNT_W  = $clog2(MAX_OPS + 1),
  localparam int IDX_W  = (MAX_OPS > 1) ? $clog2(MAX_OPS) : 1,
  localparam int LEN_W  = $clog2(MAX_OPS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] opd_count,
  output logic             base_ld,
  output logic             clear,
  output logic             rd_en,
  output logic [CNT_W-1:0] rd_off,
  output logic             cap_opc,
  output logic             cap_opd,
  output logic [IDX_W-1:0] cap_idx,
  output logic             done,
  output logic [LEN_W-1:0] len
);

  fetch_state_e      state_q, state_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  idx_q;
  logic              done_d;
  logic              last_opd;
  logic [CNT_W-1:0]  idx_next;

  assign idx_next = idx_q + CNT_W'(1);
  assign last_opd = (idx_next >= cnt_q);

  always_comb begin
    state_d  = state_q;
    req_ready = 1'b0;
    base_ld  = 1'b0;
    clear    = 1'b0;
    rd_en    = 1'b0;
    rd_off   = '0;
    cap_opc  = 1'b0;
    cap_opd  = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      FS_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          base_ld = 1'b1;
          clear   = 1'b1;
          state_d = FS_ISSUE;
        end
      end
      FS_ISSUE: begin
        rd_en   = 1'b1;
        state_d = FS_TAKE_OPC;
      end
      FS_TAKE_OPC: begin
        cap_opc = 1'b1;
        if (opd_count != '0) begin
          // Overlap: issue the first operand read while the opcode lands.
          rd_en   = 1'b1;
          rd_off  = CNT_W'(1);
          state_d = FS_TAKE_OPD;
        end else begin
          done_d  = 1'b1;
          state_d = FS_IDLE;
        end
      end
      FS_TAKE_OPD: begin
        cap_opd = 1'b1;
        if (last_opd) begin
          done_d  = 1'b1;
          state_d = FS_IDLE;
        end else begin
          rd_en   = 1'b1;
          rd_off  = idx_next + CNT_W'(1);
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  assign cap_idx = IDX_W'(idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      done    <= 1'b0;
      len     <= '0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      if (cap_opc) begin
        cnt_q <= opd_count;
        idx_q <= '0;
        len   <= LEN_W'(opd_count) + LEN_W'(1);
      end else if (cap_opd && !last_opd) begin
        idx_q <= idx_next;
      end
      if (clear) len <= '0;
    end
  end

endmodule

// File: rtl/instr_fetch_seq.sv
module instr_fetch_seq
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [MODE_W-1:0] dec_mode,
  output logic              done,
  output logic [DATA_W-1:0] out_opcode,
  output logic [DATA_W-1:0] out_op1,
  output logic [DATA_W-1:0] out_op2,
  output logic [1:0]        out_len
);

  localparam int MAX_OPS = 2;
  localparam int CNT_W   = $clog2(MAX_OPS + 1);
  localparam int IDX_W   = (MAX_OPS > 1) ? $clog2(MAX_OPS) : 1;
  localparam int LEN_W   = $clog2(MAX_OPS + 2);

  logic [CNT_W-1:0]          opd_count;
  logic                      base_ld, clear, cap_opc, cap_opd;
  logic [CNT_W-1:0]          rd_off;
  logic [IDX_W-1:0]          cap_idx;
  logic [MAX_OPS*DATA_W-1:0] operands;
  logic [LEN_W-1:0]          len;

  fetch_mode_class #(.MODE_W(MODE_W), .MAX_OPS(MAX_OPS)) u_class (
    .mode_raw  (dec_mode),
    .opd_count (opd_count)
  );

  fetch_ctrl #(.MAX_OPS(MAX_OPS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .opd_count (opd_count),
    .base_ld   (base_ld),
    .clear     (clear),
    .rd_en     (mem_rd_en),
    .rd_off    (rd_off),
    .cap_opc   (cap_opc),
    .cap_opd   (cap_opd),
    .cap_idx   (cap_idx),
    .done      (done),
    .len       (len)
  );

  fetch_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(CNT_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .base_ld (base_ld),
    .base_in (req_addr),
    .offset  (rd_off),
    .addr    (mem_addr)
  );

  fetch_byte_bank #(.DATA_W(DATA_W), .MAX_OPS(MAX_OPS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .cap_opc  (cap_opc),
    .cap_opd  (cap_opd),
    .cap_idx  (cap_idx),
    .wdata    (mem_rdata),
    .opcode   (out_opcode),
    .operands (operands)
  );

  assign out_op1 = operands[0 +: DATA_W];
  assign out_op2 = operands[DATA_W +: DATA_W];
  assign out_len = len;

endmodule

// File: rtl/instr_fetch_seq_chk.sv
module instr_fetch_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic [DATA_W-1:0] out_opcode,
  input logic [DATA_W-1:0] out_op1,
  input logic [DATA_W-1:0] out_op2,
  input logic [1:0]        out_len
);

  // R2: an idle block never drives a bus read
  assert_idle_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en);

  // R3: opcode read follows the accepting edge at the requested address
  assert_opcode_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_rd_en && mem_addr == $past(req_addr)));

  // R3: back-to-back reads step the address by one
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R8: length legal and unfetched operands are zero
  assert_len_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_len != 2'd0 && (out_len == 2'd3 || out_op2 == '0)
              && (out_len >= 2'd2 || out_op1 == '0)));

  // R9: done is a single-cycle pulse issued from idle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !mem_rd_en));

  // R10: results hold while idle and no request is taken
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(out_opcode) && $stable(out_op1)
                                   && $stable(out_op2) && $stable(out_len)));

endmodule

bind instr_fetch_seq instr_fetch_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .done       (done),
  .out_opcode (out_opcode),
  .out_op1    (out_op1),
  .out_op2    (out_op2),
  .out_len    (out_len)
);

// File: tb/instr_fetch_seq_tb.sv
`timescale 1ns/1ps
module instr_fetch_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [3:0]  dec_mode;
  logic        done;
  logic [7:0]  out_opcode, out_op1, out_op2;
  logic [1:0]  out_len;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [15:0] cur_start = '0;
  logic [7:0]  cur_opc = '0;
  int          rd_idx = 0;

  always #4 clk = ~clk;  // 125 MHz

  instr_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .dec_mode(dec_mode), .done(done),
    .out_opcode(out_opcode), .out_op1(out_op1), .out_op2(out_op2),
    .out_len(out_len)
  );

  function automatic logic [7:0] fill_byte(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic int opd_n(input logic [3:0] m);
    if (m >= 4'd10) return 2;
    if (m >= 4'd2)  return 1;
    return 0;
  endfunction

  // Decoder follows whatever byte is on the read bus (R7).
  assign dec_mode = mem_rdata[3:0];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One-cycle-latency memory; every read address is checked (R3).
  always @(posedge clk) begin
    if (mem_rd_en) begin
      logic [15:0] exp_a;
      exp_a = cur_start + 16'(rd_idx);
      n_tests++;
      if (mem_addr !== exp_a) begin
        n_fail++;
        $display("FAIL R3: read address actual %0h expected %0h", mem_addr, exp_a);
      end
      mem_rdata <= (mem_addr == cur_start) ? cur_opc : fill_byte(mem_addr);
      rd_idx++;
    end
  end

  task automatic do_fetch(input logic [15:0] start, input logic [3:0] mode,
                          input logic [3:0] hi);
    int k;
    int n;
    logic [7:0] e1, e2;
    string gtag;
    n  = opd_n(mode);
    gtag = (n == 0) ? "R6" : (n == 1) ? "R4" : "R5";
    e1 = (n >= 1) ? fill_byte(start + 16'd1) : 8'h00;
    e2 = (n == 2) ? fill_byte(start + 16'd2) : 8'h00;
    @(negedge clk);
    cur_start = start;
    cur_opc   = {hi, mode};
    rd_idx    = 0;
    chk(req_ready === 1'b1, "R2 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = start;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = 16'hDEAD;
    k = 1;
    chk(req_ready === 1'b0, "R2 busy not ready", int'(req_ready), 0);
    while (done !== 1'b1 && k < 12) begin
      @(negedge clk);
      k++;
      if (k == 2) begin req_valid = 1'b1; req_addr = start + 16'h0100; end
      if (k == 3) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    chk(k == 3 + n, "R9 done latency", k, 3 + n);
    chk(out_opcode === cur_opc, "R8 opcode", int'(out_opcode), int'(cur_opc));
    chk(out_op1 === e1, {gtag, " operand1"}, int'(out_op1), int'(e1));
    chk(out_op2 === e2, {gtag, " operand2"}, int'(out_op2), int'(e2));
    chk(out_len === 2'(1 + n), "R8 length", int'(out_len), 1 + n);
    chk(rd_idx == 1 + n, "R9 read count", rd_idx, 1 + n);
    @(negedge clk);
    chk(done === 1'b0, "R9 single pulse", int'(done), 0);
    @(negedge clk);
    chk(out_opcode === cur_opc && out_op1 === e1 && out_op2 === e2,
        "R10 hold", int'(out_op1), int'(e1));
    chk(rd_idx == 1 + n, "R2 no read from ignored request", rd_idx, 1 + n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] starts [7];
    starts = '{16'h0000, 16'h1234, 16'h7FFF, 16'h00FF,
               16'hFFFD, 16'hFFFE, 16'hFFFF};
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(req_ready === 1'b1 && done === 1'b0 && mem_rd_en === 1'b0,
        "R1 control in reset", int'({req_ready, done, mem_rd_en}), 4);
    chk(out_opcode === 8'h00 && out_op1 === 8'h00 && out_op2 === 8'h00
        && out_len === 2'd0, "R1 results in reset", int'(out_opcode), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && done === 1'b0 && mem_rd_en === 1'b0,
        "R1 after reset", int'({req_ready, done, mem_rd_en}), 4);
    for (int s = 0; s < 7; s++) begin
      for (int m = 0; m < 16; m++) begin
        do_fetch(starts[s], 4'(m), 4'(s * 3 + m));
      end
    end
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule